// File: doc/BRIEF.md
# Glitch-Free DAC Update Sequencer

This block sits between a CPU-side write port and a parallel digital-to-analog converter whose output goes through an external sample-and-hold stage. A code write is captured in an internal code register. The block then raises a one-cycle load strobe toward the converter and waits for a configurable number of settle clocks. After that it pulses the hold stage's sample control for one clock. While the converter output slews and its bits switch unevenly, the hold stage keeps showing the old level. The worst case for uneven switching is a major carry step such as 0x80 to 0x7F. The analog output therefore only moves to the new level once it has settled to within half an LSB.

A busy flag tells the CPU that a sequence is running. A write that arrives while busy is parked in a single-entry holding slot and started once the current sequence ends. A later write replaces the value in the slot, so only the newest code ever reaches the converter. After reset the code register is zero and one full load/settle/sample sequence runs, so the hold stage starts from a known level.

Top module: `dac_glitchless_seq`

## Requirements
- R1: After reset is released, `dac_code` is 0, `busy` is 1 and `dac_le` is 1. One complete sequence then follows, ending in exactly one `sh_sample` pulse.
- R2: A write (`wr_en`=1 at a clock edge) accepted while idle makes `dac_le` high for exactly one cycle, starting the cycle after the write. In that cycle `dac_code` already equals the written `wr_data`.
- R3: After the `dac_le` cycle, `sh_sample` stays 0 for exactly S cycles, where S = `settle_len` (a value of 0 counts as 1). It is then 1 for exactly one cycle.
- R4: `busy` is 1 from the `dac_le` cycle through the `sh_sample` cycle. It is 0 in the cycle after the pulse when nothing is waiting.
- R5: A write that arrives while `busy` is 1 is not applied immediately. It starts a new sequence one idle cycle after the current `sh_sample` pulse.
- R6: When several writes arrive during one busy period, only the last one is applied. The earlier values never appear on `dac_code`.
- R7: A write whose code equals the current `dac_code` still runs the full load, settle and sample sequence.
- R8: `dac_le` and `sh_sample` are never high together. `dac_code` changes only in a cycle where `dac_le` is 1.
- R9: A direct write in the idle cycle that follows a queued write takes precedence. The queued value is discarded and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe from the CPU side |
| wr_data | input | CODE_W | Code to write |
| settle_len | input | SETL_W | Settle length in clocks, captured at the load cycle; 0 acts as 1 |
| busy | output | 1 | High while a sequence is running |
| dac_code | output | CODE_W | Latched code driving the converter |
| dac_le | output | 1 | One-cycle load strobe toward the converter |
| sh_sample | output | 1 | One-cycle sample pulse to the hold stage |

## Verification
The hardest situations to reach from the ports are the ones involving the holding slot. One is a write overwritten by a later one during the same busy period. The other is a direct write that lands in the single idle cycle while a queued value is still waiting. The stimulus reaches both by choosing a long settle length and driving writes on fixed cycle offsets from the observed `dac_le` and `sh_sample` edges, so the write lands exactly in the settle, sample or following idle cycle. The carry step 0x80 to 0x7F, a repeated equal code and a zero settle length come from the vector table.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LATCH  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_SAMPLE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dac_code_latch.sv
module dac_code_latch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  output logic              start,
  output logic [CODE_W-1:0] code_q
);
  logic              pend_v_q, pend_v_d;
  logic [CODE_W-1:0] pend_d_q;
  logic [CODE_W-1:0] code_d;
  logic              code_en, pend_en;

  // a new sequence starts from idle on a direct write or a parked one
  assign start   = idle & (wr_en | pend_v_q);
  assign code_en = start;
  assign code_d  = wr_en ? wr_data : pend_d_q;
  assign pend_en = ~idle & wr_en;

  always_comb begin
    pend_v_d = pend_v_q;
    if (pend_en)     pend_v_d = 1'b1;
    else if (start)  pend_v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
    end else begin
      pend_v_q <= pend_v_d;
      if (code_en) code_q   <= code_d;
      if (pend_en) pend_d_q <= wr_data;
    end
  end
endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
  import dac_seq_pkg::*;
#(
  parameter int SETL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SETL_W-1:0] settle_len,
  output seq_state_e        state
);
  localparam logic [SETL_W-1:0] ONE = SETL_W'(1);

  seq_state_e        state_d;
  logic [SETL_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    state_d = state;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state)
      ST_IDLE:   if (start) state_d = ST_LATCH;
      ST_LATCH: begin
        cnt_en  = 1'b1;
        cnt_d   = (settle_len == '0) ? ONE : settle_len;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - ONE;
        if (cnt_q == ONE) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LATCH;
      cnt_q <= '0;
    end else begin
      state <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dac_glitchless_seq.sv
module dac_glitchless_seq
  import dac_seq_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SETL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [SETL_W-1:0] settle_len,
  output logic              busy,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_le,
  output logic              sh_sample
);
  logic       rst_meta_q, rst_sync_n;
  logic       start;
  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dac_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .idle    (state == ST_IDLE),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .start   (start),
    .code_q  (dac_code)
  );

  dac_seq_fsm #(.SETL_W(SETL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .settle_len (settle_len),
    .state      (state)
  );

  assign busy      = (state != ST_IDLE);
  assign dac_le    = (state == ST_LATCH);
  assign sh_sample = (state == ST_SAMPLE);
endmodule

// File: rtl/dac_seq_chk.sv
module dac_seq_chk #(
  parameter int CODE_W = 8,
  parameter int SETL_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [SETL_W-1:0] settle_len,
  input logic              busy,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_le,
  input logic              sh_sample
);
  logic [SETL_W:0]   gap_q;
  logic [SETL_W-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gap_q <= '0;
      exp_q <= SETL_W'(1);
    end else if (dac_le) begin
      gap_q <= '0;
      exp_q <= (settle_len == '0) ? SETL_W'(1) : settle_len;
    end else if (!sh_sample) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r8_le_sample_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dac_le && sh_sample));
  a_r8_code_moves_on_le: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(dac_code) |-> dac_le);
  a_r3_sample_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sh_sample |=> !sh_sample);
  a_r3_no_sample_after_le: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dac_le |=> !sh_sample && !dac_le);
  a_r3_settle_length: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sh_sample |-> gap_q == {1'b0, exp_q});
  a_r4_busy_cover: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dac_le || sh_sample) |-> busy);
  a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> $past(sh_sample));
endmodule

bind dac_glitchless_seq dac_seq_chk #(.CODE_W(CODE_W), .SETL_W(SETL_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .settle_len (settle_len),
  .busy       (busy),
  .dac_code   (dac_code),
  .dac_le     (dac_le),
  .sh_sample  (sh_sample)
);

// File: tb/dac_glitchless_seq_tb.sv
module dac_glitchless_seq_tb;
  localparam int CODE_W = 8;
  localparam int SETL_W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 6;
  // each entry: {code, settle_len}
  localparam logic [CODE_W+SETL_W-1:0] VEC [NVEC] = '{
    {8'h80, 8'd3}, {8'h7F, 8'd5}, {8'h7F, 8'd2},
    {8'h00, 8'd0}, {8'hFF, 8'd1}, {8'h55, 8'd9}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [CODE_W-1:0] wr_data;
  logic [SETL_W-1:0] settle_len;
  logic              busy, dac_le, sh_sample;
  logic [CODE_W-1:0] dac_code;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_glitchless_seq #(.CODE_W(CODE_W), .SETL_W(SETL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .settle_len(settle_len), .busy(busy), .dac_code(dac_code),
    .dac_le(dac_le), .sh_sample(sh_sample)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge inside the load cycle; ends at the sample-cycle negedge
  task automatic observe(input logic [CODE_W-1:0] code, input int settle, input string req);
    int n = 0;
    int want = (settle == 0) ? 1 : settle;
    chk({req, " R2 le"}, int'(dac_le), 1);
    chk({req, " R2 code"}, int'(dac_code), int'(code));
    chk({req, " R4 busy at le"}, int'(busy), 1);
    @(negedge clk);
    while (!sh_sample && n < 400) begin
      if (dac_le || dac_code != code) chk({req, " R8 quiet settle"}, 1, 0);
      n++;
      @(negedge clk);
    end
    chk({req, " R3 settle cycles"}, n, want);
    chk({req, " R4 busy at sample"}, int'(busy), 1);
  endtask

  task automatic write(input logic [CODE_W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; settle_len = 8'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: reset sequence with zero code and one sample pulse
    observe(8'h00, 2, "R1");
    @(negedge clk);
    chk("R1 idle after reset seq", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R1 no second sample", int'(sh_sample), 0);

    // table walk: carry step, equal code (R7), zero settle
    for (int i = 0; i < NVEC; i++) begin
      settle_len = VEC[i][SETL_W-1:0];
      write(VEC[i][CODE_W+SETL_W-1:SETL_W]);
      observe(VEC[i][CODE_W+SETL_W-1:SETL_W], int'(VEC[i][SETL_W-1:0]),
              (i == 2) ? "R7 vec" : "vec");
      @(negedge clk);
      chk("R4 busy low after sample", int'(busy), 0);
    end

    // R5/R6: queue then overwrite during a long settle
    settle_len = 8'd6;
    write(8'hA1);
    chk("R5 first write le", int'(dac_le), 1);
    chk("R5 first code", int'(dac_code), 8'hA1);
    wr_en = 1'b1; wr_data = 8'hB2;
    @(negedge clk);
    wr_data = 8'hC3;
    @(negedge clk);
    wr_en = 1'b0;
    while (!sh_sample) begin
      if (dac_code != 8'hA1) chk("R5 code held while busy", int'(dac_code), 8'hA1);
      @(negedge clk);
    end
    @(negedge clk);
    chk("R5 idle gap busy", int'(busy), 0);
    chk("R5 idle gap le", int'(dac_le), 0);
    @(negedge clk);
    observe(8'hC3, 6, "R6 last write wins");
    @(negedge clk);
    chk("R6 no leftover", int'(busy), 0);

    // R9: queued write in sample cycle, direct write in the following idle cycle
    settle_len = 8'd2;
    write(8'h11);
    while (!sh_sample) @(negedge clk);
    write(8'h22);
    chk("R9 idle with pending", int'(busy), 0);
    write(8'h33);
    observe(8'h33, 2, "R9 direct wins");
    @(negedge clk);
    chk("R9 no queued replay busy", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R9 code kept", int'(dac_code), 8'h33);
    chk("R9 still idle", int'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule